// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block keeps the single reservation that a processor core holds for its load-reserve / store-conditional pairs. The load/store unit presents one request per cycle, either a load-reserve or a store-conditional, along with its effective address. A load-reserve places a reservation on the 16-byte granule holding that address and replaces any earlier one. A store-conditional asks whether its store may go ahead. The answer depends only on whether a reservation is held, and the request always gives the reservation up.

A separate snoop port carries the addresses of writes made by other bus masters. A snooped write that lands in the reserved granule cancels the reservation. Atomic requests whose address is not word aligned are rejected with an alignment fault and leave the reservation as it was. The block never raises a data-storage fault for these requests. The reservation valid bit and granule address come out on debug ports.

Top module: `rsv_monitor`

## Requirements
- R1: While reset is low and on the first cycle after it, `dbg_rsv_valid`, `sc_done_valid`, `sc_success`, `align_fault` and `dsi_fault` are all 0.
- R2: A word-aligned load-reserve (`req_type` = 0) sets `dbg_rsv_valid` on the next cycle. `dbg_rsv_addr` then equals the request address with bits [3:0] cleared, replacing any earlier reservation.
- R3: A word-aligned store-conditional (`req_type` = 1) gives `sc_done_valid` = 1 for exactly the next cycle. `sc_success` in that cycle is 1 exactly when a reservation was valid, with no comparison of addresses.
- R4: Every word-aligned store-conditional leaves `dbg_rsv_valid` at 0 on the next cycle, whether it succeeds or fails.
- R5: A snoop whose address matches the reservation in bits [31:4] clears the reservation. A snoop that differs anywhere in bits [31:4] leaves it unchanged.
- R6: A request with address bits [1:0] not equal to 0 gives `align_fault` = 1 on the next cycle and no `sc_done_valid`, and the request does not change the reservation.
- R7: `dsi_fault` stays 0 for every atomic request, in both values of `wt_mode`.
- R8: A store-conditional and a snoop hitting the reserved granule in the same cycle make the store-conditional fail.
- R9: A load-reserve and a snoop hitting the old reservation's granule in the same cycle leave the new reservation valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Atomic request present this cycle |
| req_type | input | 1 | 0 = load-reserve, 1 = store-conditional |
| req_addr | input | 32 | Effective address of the request |
| wt_mode | input | 1 | Access is to write-through memory |
| snoop_valid | input | 1 | Another master writes this cycle |
| snoop_addr | input | 32 | Address of the snooped write |
| sc_done_valid | output | 1 | One-cycle pulse carrying a store-conditional result |
| sc_success | output | 1 | Store-conditional may perform its store |
| align_fault | output | 1 | Previous request was misaligned |
| dsi_fault | output | 1 | Data-storage fault indication (never raised here) |
| dbg_rsv_valid | output | 1 | Reservation held |
| dbg_rsv_addr | output | 32 | Reserved granule address, low 4 bits zero |

## Verification
The bench sweeps all four byte offsets against both request kinds and both `wt_mode` values. This separates the aligned path from the fault path, and shows that the write-through mode never brings out a data-storage fault. A snoop is moved byte by byte across the reserved granule and its two neighbours, and a store-conditional to an unrelated address follows each one. The result marks the exact granule edges and shows that the store-conditional address is never compared. Same-cycle collisions check the priority rules: store-conditional with a hitting or missing snoop, and load-reserve with a snoop on the old granule. Chained sequences cover replacement by a second load-reserve and back-to-back store-conditionals.

// File: rtl/rsv_pkg.sv
// Package: shared request encoding for the reservation monitor.
// Assumes a one-bit request kind field driven by the load/store unit.
package rsv_pkg;
    typedef enum logic {
        REQ_LOAD_RSV   = 1'b0,
        REQ_STORE_COND = 1'b1
    } req_kind_e;
endpackage

// File: rtl/rsv_align_chk.sv
// Module: rsv_align_chk
// Tells whether an address is aligned to WORD_BYTES.
// Assumes WORD_BYTES is a power of two.
module rsv_align_chk #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              aligned
);
    localparam int OFS_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;

    generate
        if (OFS_W == 0) begin : g_byte
            logic unused_addr;
            // No offset bits: every address is aligned.
            assign unused_addr = &{1'b0, addr};
            assign aligned     = 1'b1;
        end else begin : g_word
            localparam logic [ADDR_W-1:0] LO_MASK = ADDR_W'((64'd1 << OFS_W) - 64'd1);
            // Aligned when all offset bits are zero.
            assign aligned = ((addr & LO_MASK) == '0);
        end
    endgenerate
endmodule

// File: rtl/rsv_granule_cmp.sv
// Module: rsv_granule_cmp
// Tells whether two addresses fall in the same reservation granule.
// Assumes GRANULE_BYTES is a power of two.
module rsv_granule_cmp #(
    parameter int ADDR_W        = 32,
    parameter int GRANULE_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same
);
    localparam int G_W = (GRANULE_BYTES > 1) ? $clog2(GRANULE_BYTES) : 0;
    localparam logic [ADDR_W-1:0] HI_MASK = ~ADDR_W'((64'd1 << G_W) - 64'd1);

    // Compare only the bits above the granule offset.
    assign same = ((addr_a & HI_MASK) == (addr_b & HI_MASK));
endmodule

// File: rtl/rsv_store.sv
// Module: rsv_store
// Holds the reservation valid bit and its granule-aligned address.
// Assumes set has priority over clr. The address is meaningless while
// valid is low.
module rsv_store #(
    parameter int ADDR_W        = 32,
    parameter int GRANULE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic              clr,
    input  logic [ADDR_W-1:0] set_addr,
    output logic              valid,
    output logic [ADDR_W-1:0] addr
);
    localparam int G_W = (GRANULE_BYTES > 1) ? $clog2(GRANULE_BYTES) : 0;
    localparam logic [ADDR_W-1:0] HI_MASK = ~ADDR_W'((64'd1 << G_W) - 64'd1);

    // Valid bit: reset clears, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   valid <= 1'b0;
        else if (set) valid <= 1'b1;
        else if (clr) valid <= 1'b0;
    end

    // Address register: loads the granule base on a set.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr <= '0;
        else if (set) addr <= set_addr & HI_MASK;
    end
endmodule

// File: rtl/rsv_result.sv
// Module: rsv_result
// Registers the per-request results so that they appear one cycle after
// the request. Assumes its inputs are already qualified by the decoder.
module rsv_result (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_fire,
    input  logic sc_pass,
    input  logic misaligned,
    output logic sc_done_valid,
    output logic sc_success,
    output logic align_fault
);
    // Result pulses: one cycle each, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done_valid <= 1'b0;
            sc_success    <= 1'b0;
            align_fault   <= 1'b0;
        end else begin
            sc_done_valid <= sc_fire;
            sc_success    <= sc_fire & sc_pass;
            align_fault   <= misaligned;
        end
    end
endmodule

// File: rtl/rsv_monitor.sv
// Module: rsv_monitor (top)
// Tracks one load-reserve / store-conditional reservation. It decodes the
// request, checks alignment, matches snoops by granule, updates the
// reservation and registers the results. Assumes at most one request and
// one snoop per cycle. A load-reserve beats a same-cycle snoop. A snoop is
// evaluated before a same-cycle store-conditional.
module rsv_monitor #(
    parameter int ADDR_W        = 32,
    parameter int WORD_BYTES    = 4,
    parameter int GRANULE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wt_mode,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              sc_done_valid,
    output logic              sc_success,
    output logic              align_fault,
    output logic              dsi_fault,
    output logic              dbg_rsv_valid,
    output logic [ADDR_W-1:0] dbg_rsv_addr
);
    import rsv_pkg::*;

    logic              req_aligned;
    logic              snoop_same;
    logic              snoop_hit;
    logic              lr_fire;
    logic              sc_fire;
    logic              misaligned;
    logic              rsv_valid;
    logic [ADDR_W-1:0] rsv_addr;
    logic              unused_wt;

    rsv_align_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_align (
        .addr    (req_addr),
        .aligned (req_aligned)
    );

    rsv_granule_cmp #(.ADDR_W(ADDR_W), .GRANULE_BYTES(GRANULE_BYTES)) u_snoop_cmp (
        .addr_a (snoop_addr),
        .addr_b (rsv_addr),
        .same   (snoop_same)
    );

    // Request decode: qualify by kind and alignment.
    always_comb begin
        lr_fire    = req_valid && req_aligned && (req_kind_e'(req_type) == REQ_LOAD_RSV);
        sc_fire    = req_valid && req_aligned && (req_kind_e'(req_type) == REQ_STORE_COND);
        misaligned = req_valid && !req_aligned;
        snoop_hit  = snoop_valid && rsv_valid && snoop_same;
    end

    rsv_store #(.ADDR_W(ADDR_W), .GRANULE_BYTES(GRANULE_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (lr_fire),
        .clr      (sc_fire || snoop_hit),
        .set_addr (req_addr),
        .valid    (rsv_valid),
        .addr     (rsv_addr)
    );

    rsv_result u_result (
        .clk           (clk),
        .rst_n         (rst_n),
        .sc_fire       (sc_fire),
        .sc_pass       (rsv_valid && !snoop_hit),
        .misaligned    (misaligned),
        .sc_done_valid (sc_done_valid),
        .sc_success    (sc_success),
        .align_fault   (align_fault)
    );

    // Atomic accesses never raise a data-storage fault, write-through or not.
    assign unused_wt = &{1'b0, wt_mode};
    assign dsi_fault = 1'b0;

    assign dbg_rsv_valid = rsv_valid;
    assign dbg_rsv_addr  = rsv_addr;
endmodule

// File: rtl/rsv_monitor_checker.sv
// Module: rsv_monitor_checker
// Temporal properties of the reservation monitor, attached by bind.
// Assumes the default 32-bit address, word and 16-byte granule sizes.
module rsv_monitor_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_type,
    input logic [31:0] req_addr,
    input logic        snoop_valid,
    input logic [31:0] snoop_addr,
    input logic        sc_done_valid,
    input logic        sc_success,
    input logic        align_fault,
    input logic        dbg_rsv_valid,
    input logic [31:0] dbg_rsv_addr
);
    logic a_ok, a_lr, a_sc, a_hit;
    // Observed request classes, from the ports.
    always_comb begin
        a_ok  = (req_addr[1:0] == 2'b00);
        a_lr  = req_valid && a_ok && !req_type;
        a_sc  = req_valid && a_ok && req_type;
        a_hit = snoop_valid && dbg_rsv_valid && (snoop_addr[31:4] == dbg_rsv_addr[31:4]);
    end

    p_lr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        a_lr |=> dbg_rsv_valid && (dbg_rsv_addr == {$past(req_addr[31:4]), 4'h0}));
    p_sc_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        a_sc |=> sc_done_valid);
    p_no_rsv_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sc && !dbg_rsv_valid) |=> !sc_success);
    p_success_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sc_success |-> sc_done_valid);
    p_sc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_sc |=> !dbg_rsv_valid);
    p_snoop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && !a_lr) |=> !dbg_rsv_valid);
    p_misalign_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !a_ok) |=> align_fault && !sc_done_valid);
    p_misalign_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !a_ok && !snoop_valid) |=> $stable(dbg_rsv_valid) && $stable(dbg_rsv_addr));
    p_sc_snoop_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sc && a_hit) |=> !sc_success);
    p_lr_beats_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_lr && a_hit) |=> dbg_rsv_valid);
endmodule

bind rsv_monitor rsv_monitor_checker u_chk (.*);

// File: tb/rsv_monitor_bench.sv
// Bench: sweeps offsets, kinds, modes and snoop positions against an
// arithmetic model of the reservation.
module rsv_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_type = 1'b0;
    logic [31:0] req_addr = '0;
    logic        wt_mode = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        sc_done_valid, sc_success, align_fault, dsi_fault, dbg_rsv_valid;
    logic [31:0] dbg_rsv_addr;

    int checks = 0;
    int errors = 0;
    bit m_valid = 1'b0;
    logic [31:0] m_addr = '0;

    always #5 clk = ~clk;

    rsv_monitor u_rsv_monitor (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, check at the next falling edge.
    task automatic cyc(input string tag, input bit rv, input bit rt, input logic [31:0] ra,
                       input bit sv, input logic [31:0] sa, input bit wt);
        bit ok, hit, e_done, e_succ, e_al;
        ok     = (ra % 4) == 0;
        hit    = sv && m_valid && ((sa / 16) == (m_addr / 16));
        e_done = rv && rt && ok;
        e_succ = e_done && m_valid && !hit;
        e_al   = rv && !ok;
        if (rv && !rt && ok) begin
            m_valid = 1'b1;
            m_addr  = (ra / 16) * 16;
        end else if (e_done || hit) begin
            m_valid = 1'b0;
        end
        req_valid = rv; req_type = rt; req_addr = ra;
        snoop_valid = sv; snoop_addr = sa; wt_mode = wt;
        @(negedge clk);
        req_valid = 1'b0; snoop_valid = 1'b0;
        chk(tag, "sc_done_valid", 32'(sc_done_valid), 32'(e_done));
        chk(tag, "sc_success", 32'(sc_success), 32'(e_succ));
        chk("R6", "align_fault", 32'(align_fault), 32'(e_al));
        chk("R7", "dsi_fault", 32'(dsi_fault), 32'h0);
        chk(tag, "dbg_rsv_valid", 32'(dbg_rsv_valid), 32'(m_valid));
        if (m_valid) chk(tag, "dbg_rsv_addr", dbg_rsv_addr, m_addr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "dbg_rsv_valid", 32'(dbg_rsv_valid), 0);
        chk("R1", "sc_done_valid", 32'(sc_done_valid), 0);
        chk("R1", "align_fault", 32'(align_fault), 0);
        rst_n = 1'b1;
        cyc("R1", 0, 0, 0, 0, 0, 0);
        // R3: store-conditional with no reservation fails
        cyc("R3", 1, 1, 32'h0000_0100, 0, 0, 0);
        // R6 / R7 / R3: sweep offsets, kinds and modes after a fresh reservation
        for (int off = 0; off < 4; off++)
            for (int t = 0; t < 2; t++)
                for (int wt = 0; wt < 2; wt++) begin
                    cyc("R2", 1, 0, 32'h1000_0044, 0, 0, wt[0]);
                    cyc("R6", 1, t[0], 32'h3000_0200 + 32'(off), 0, 0, wt[0]);
                    cyc("R4", 1, 1, 32'h0, 0, 0, wt[0]);
                end
        // R5: snoop moved across the reserved granule, then an unrelated SC (R3 no compare)
        for (int d = -24; d <= 40; d++) begin
            cyc("R2", 1, 0, 32'h2000_0108, 0, 0, 0);
            cyc("R5", 0, 0, 0, 1, 32'h2000_0100 + 32'(d), 0);
            cyc("R3", 1, 1, 32'h7777_0000, 0, 0, 0);
        end
        // R8: same-cycle SC with hitting then missing snoop
        cyc("R2", 1, 0, 32'h4000_0010, 0, 0, 0);
        cyc("R8", 1, 1, 32'h4000_0010, 1, 32'h4000_001C, 0);
        cyc("R2", 1, 0, 32'h4000_0010, 0, 0, 1);
        cyc("R8", 1, 1, 32'h4000_0010, 1, 32'h4000_0020, 1);
        // R9: load-reserve with a snoop on the old granule
        cyc("R2", 1, 0, 32'h5000_0030, 0, 0, 0);
        cyc("R9", 1, 0, 32'h5000_0034, 1, 32'h5000_0038, 0);
        cyc("R9", 1, 1, 32'h0, 0, 0, 0);
        // R2: replacement; snoop on old granule ignored, new one clears
        cyc("R2", 1, 0, 32'h6000_0000, 0, 0, 0);
        cyc("R2", 1, 0, 32'h6000_0F04, 0, 0, 0);
        cyc("R5", 0, 0, 0, 1, 32'h6000_0004, 0);
        cyc("R5", 0, 0, 0, 1, 32'h6000_0F0F, 0);
        // R4: back-to-back store-conditionals
        cyc("R2", 1, 0, 32'h6100_0000, 0, 0, 0);
        cyc("R4", 1, 1, 32'h6100_0000, 0, 0, 0);
        cyc("R4", 1, 1, 32'h6100_0000, 0, 0, 0);
        // R6: misaligned request with a reservation held leaves it intact
        cyc("R2", 1, 0, 32'h6200_0020, 0, 0, 0);
        cyc("R6", 1, 0, 32'h6300_0002, 0, 0, 0);
        cyc("R6", 1, 1, 32'h6200_0023, 0, 0, 1);
        cyc("R3", 1, 1, 32'h6200_0020, 0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule